// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns four channels of parallel 24-bit audio samples into serial data. A receiver supplies the bit clock and frame sync. A 2-bit format select picks one of three framings. In the two-channel framings (left-justified and I²S), each of two data pins carries one left/right channel pair. In the four-slot TDM framing, all four channels leave on one pin within a single frame.

The bit clock and frame sync are sampled in the local clock domain. The serial outputs change only after a detected falling edge of the bit clock, so a receiver can latch them on the rising edge. Samples arrive through a valid/ready handshake into a holding register. The holding register is copied into the active sample set only at the start of a frame, so a load in mid-frame never changes the frame on the wire.

Top module: `aud_ser_tx`

## Requirements
- R1: `fmt_i` selects the framing: 00 is left-justified, 01 is I²S, 10 is TDM. Under code 11 both bits of `sdata_o` are driven 0.
- R2: `sdata_o` changes only within two `clk_i` cycles after a falling edge of `sclk_i`. It stays constant while `sclk_i` is high.
- R3: In TDM, a rising `fs_i` (seen at a falling `sclk_i` edge) starts a frame of four 32-bit slots, channels 1 to 4 in order, all on `sdata_o[0]`. `sdata_o[1]` is held 0.
- R4: Each TDM slot carries its 24-bit sample MSB first from the slot's first bit, followed by 8 zero bits.
- R5: In left-justified mode, the MSB leaves on the same falling edge at which `fs_i` changes level. With `fs_i` high, `sdata_o[0]`/`sdata_o[1]` carry channel 1/3. With `fs_i` low, they carry channel 2/4. Bits after the 24th are 0.
- R6: In I²S mode, the MSB leaves one bit clock after the `fs_i` change, and the bit at the change itself is 0. With `fs_i` low the pins carry channel 1/3, and with `fs_i` high they carry channel 2/4.
- R7: `ld_ready_o` is high exactly when the holding register is empty. A word is taken when `ld_valid_i` and `ld_ready_o` are both high. `ld_ready_o` then stays low until the next frame start.
- R8: The held word becomes active at the frame start: a rising `fs_i` for left-justified and TDM, a falling `fs_i` for I²S. A load during a frame leaves that frame unchanged and appears in the next one.
- R9: After reset, `sdata_o` is 0 and `ld_ready_o` is 1, and the active samples are all zero until the first load is taken.

Channel c (1 to 4) sits in `ld_data_i[24*c-1 -: 24]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | Framing select |
| sclk_i | input | 1 | Bit clock from the receiver |
| fs_i | input | 1 | Frame sync from the receiver |
| ld_valid_i | input | 1 | Sample word offered |
| ld_data_i | input | 96 | Four packed 24-bit samples, channel 1 lowest |
| ld_ready_o | output | 1 | Holding register empty |
| sdata_o | output | 2 | Serial data pins |

## Verification
The hardest case to reach is a load that lands in the middle of a frame, because the bit clock must be partway through a frame at the moment the handshake completes. The bench drives the bit clock and frame sync itself. During bit 10 of a chosen frame it performs the load, then checks that the rest of that frame still carries the old samples and that the next frame carries the new ones. It does this in every framing, including across format switches where an idle frame-sync level makes the next edge a frame start.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;
  localparam int SAMPLE_W = 24;
  localparam int SLOT_W   = 32;
  localparam int N_CH     = 4;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_TDM = 2'b10,
    FMT_RSV = 2'b11
  } fmt_e;
endpackage

// File: rtl/aud_ser_edge.sv
module aud_ser_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic fs_i,
  output logic fall_o,
  output logic fs_lvl_o,
  output logic fs_rise_o,
  output logic fs_fall_o
);
  logic [1:0] sclk_q;
  logic       fs_q;
  logic       fs_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 2'b00;
      fs_q      <= 1'b0;
      fs_prev_q <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[0], sclk_i};
      fs_q   <= fs_i;
      if (fall_o) fs_prev_q <= fs_q;
    end
  end

  assign fall_o    = sclk_q[1] & ~sclk_q[0];
  assign fs_lvl_o  = fs_q;
  // frame sync level is judged against its value at the previous bit edge
  assign fs_rise_o = fall_o & fs_q & ~fs_prev_q;
  assign fs_fall_o = fall_o & ~fs_q & fs_prev_q;
endmodule

// File: rtl/aud_ser_seq.sv
module aud_ser_seq #(
  parameter int SLOT_W = aud_ser_pkg::SLOT_W,
  parameter int N_CH   = aud_ser_pkg::N_CH,
  localparam int POS_MAX = N_CH * SLOT_W,
  localparam int POS_W   = $clog2(POS_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             fs_rise_i,
  input  logic             fs_fall_i,
  input  logic [1:0]       fmt_i,
  output logic             frame_start_o,
  output logic [POS_W-1:0] pos_o
);
  import aud_ser_pkg::*;

  fmt_e             fmt;
  logic             restart;
  logic [POS_W-1:0] pos_q;

  assign fmt = fmt_e'(fmt_i);

  // TDM restarts only on the rising sync; two-channel modes on either edge
  assign restart       = (fmt == FMT_TDM) ? fs_rise_i : (fs_rise_i | fs_fall_i);
  assign frame_start_o = (fmt == FMT_I2S) ? fs_fall_i : fs_rise_i;

  always_comb begin
    if (restart)                         pos_o = '0;
    else if (pos_q == POS_W'(POS_MAX))   pos_o = pos_q;
    else                                 pos_o = pos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= POS_W'(POS_MAX);
    else if (fall_i) pos_q <= pos_o;
  end
endmodule

// File: rtl/aud_ser_hold.sv
module aud_ser_hold #(
  parameter int SAMPLE_W = aud_ser_pkg::SAMPLE_W,
  parameter int N_CH     = aud_ser_pkg::N_CH,
  localparam int WORD_W  = SAMPLE_W * N_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic [WORD_W-1:0] ld_data_i,
  output logic              ld_ready_o,
  input  logic              frame_start_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] pend_q;
  logic [WORD_W-1:0] act_q;
  logic              pend_vld_q;
  logic              accept;
  logic              swap;

  assign ld_ready_o = ~pend_vld_q;
  assign accept     = ld_valid_i & ld_ready_o;
  assign swap       = frame_start_i & pend_vld_q;
  // the first bit of a new frame must already see the new word
  assign word_o     = swap ? pend_q : act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      act_q      <= '0;
      pend_vld_q <= 1'b0;
    end else if (swap) begin
      act_q      <= pend_q;
      pend_vld_q <= 1'b0;
    end else if (accept) begin
      pend_q     <= ld_data_i;
      pend_vld_q <= 1'b1;
    end
  end

  a_r7_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i && ld_ready_o |=> !ld_ready_o)
    else $error("R7: ready stayed high after accept");

  a_r8_swap_at_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(frame_start_i))
    else $error("R8: active samples changed outside frame start");
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
  parameter int SAMPLE_W = aud_ser_pkg::SAMPLE_W,
  parameter int SLOT_W   = aud_ser_pkg::SLOT_W,
  parameter int N_CH     = aud_ser_pkg::N_CH,
  localparam int N_PIN   = N_CH / 2,
  localparam int WORD_W  = SAMPLE_W * N_CH,
  localparam int IDX_W   = $clog2(WORD_W),
  localparam int POS_MAX = N_CH * SLOT_W,
  localparam int POS_W   = $clog2(POS_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        fmt_i,
  input  logic              sclk_i,
  input  logic              fs_i,
  input  logic              ld_valid_i,
  input  logic [WORD_W-1:0] ld_data_i,
  output logic              ld_ready_o,
  output logic [N_PIN-1:0]  sdata_o
);
  import aud_ser_pkg::*;

  fmt_e              fmt;
  logic              fall_ev, fs_lvl, fs_rise, fs_fall;
  logic              frame_start;
  logic [POS_W-1:0]  pos;
  logic [WORD_W-1:0] word;
  logic [N_PIN-1:0]  pair_bit;
  logic [N_PIN-1:0]  nxt;
  logic [N_PIN-1:0]  sdata_q;
  logic              right;
  logic              pair_ok;
  logic              tdm_ok;
  logic              tdm_bit;
  logic [IDX_W-1:0]  tdm_idx;
  int                p;
  int                b2;

  assign fmt = fmt_e'(fmt_i);

  aud_ser_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_i    (sclk_i),
    .fs_i      (fs_i),
    .fall_o    (fall_ev),
    .fs_lvl_o  (fs_lvl),
    .fs_rise_o (fs_rise),
    .fs_fall_o (fs_fall)
  );

  aud_ser_seq #(.SLOT_W(SLOT_W), .N_CH(N_CH)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fall_i        (fall_ev),
    .fs_rise_i     (fs_rise),
    .fs_fall_i     (fs_fall),
    .fmt_i         (fmt_i),
    .frame_start_o (frame_start),
    .pos_o         (pos)
  );

  aud_ser_hold #(.SAMPLE_W(SAMPLE_W), .N_CH(N_CH)) u_hold (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ld_valid_i    (ld_valid_i),
    .ld_data_i     (ld_data_i),
    .ld_ready_o    (ld_ready_o),
    .frame_start_i (frame_start),
    .word_o        (word)
  );

  // bit position inside the current slot or half frame
  always_comb begin
    p      = int'(pos);
    right  = (fmt == FMT_I2S) ? fs_lvl : ~fs_lvl;
    b2     = (fmt == FMT_I2S) ? p - 1 : p;
    pair_ok = (b2 >= 0) && (b2 < SAMPLE_W);
    if (!pair_ok) b2 = 0;
    tdm_ok  = (p < POS_MAX) && ((p % SLOT_W) < SAMPLE_W);
    tdm_idx = tdm_ok ? IDX_W'((p / SLOT_W) * SAMPLE_W + SAMPLE_W - 1 - (p % SLOT_W))
                     : '0;
  end

  assign tdm_bit = word[tdm_idx];

  for (genvar q = 0; q < N_PIN; q++) begin : g_pin
    logic [IDX_W-1:0] idx;
    always_comb idx = IDX_W'((2 * q + int'(right)) * SAMPLE_W + SAMPLE_W - 1 - b2);
    assign pair_bit[q] = word[idx];
  end

  always_comb begin
    nxt = '0;
    case (fmt)
      FMT_LJ, FMT_I2S: if (pair_ok) nxt = pair_bit;
      FMT_TDM:         nxt[0] = tdm_ok & tdm_bit;
      default:         nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sdata_q <= '0;
    else if (fall_ev) sdata_q <= nxt;
  end

  assign sdata_o = sdata_q;

  a_r1_reserved_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_ev && fmt == FMT_RSV |=> sdata_o == '0)
    else $error("R1: reserved code drove data");

  a_r2_update_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> $past(fall_ev))
    else $error("R2: data moved without a bit clock fall");

  a_r3_tdm_spare_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_ev && fmt == FMT_TDM |=> (sdata_o >> 1) == '0)
    else $error("R3: spare pin active in TDM");

  a_r4_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_ev && fmt == FMT_TDM && (int'(pos) % SLOT_W) >= SAMPLE_W |=> !sdata_o[0])
    else $error("R4: slot tail not zero");

  a_r6_i2s_lead_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_ev && fmt == FMT_I2S && (fs_rise || fs_fall) |=> sdata_o == '0)
    else $error("R6: I2S bit at sync change not zero");
endmodule

// File: tb/aud_ser_tx_tb.sv
module aud_ser_tx_tb;
  localparam int W  = 24;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    fmt;
  logic          sclk, fs, ld_valid;
  logic [NC*W-1:0] ld_data;
  logic          ld_ready;
  logic [1:0]    sdata;

  int            n_chk = 0;
  int            n_fail = 0;
  logic          done = 1'b0;
  logic [NC*W-1:0] cur_w, pend_w;
  logic          pend_vld;

  always #2 clk = ~clk;

  aud_ser_tx u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .fmt_i      (fmt),
    .sclk_i     (sclk),
    .fs_i       (fs),
    .ld_valid_i (ld_valid),
    .ld_data_i  (ld_data),
    .ld_ready_o (ld_ready),
    .sdata_o    (sdata)
  );

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic bit_of(input int ch, input int b);
    logic [NC*W-1:0] t;
    t = cur_w >> (ch * W + W - 1 - b);
    return t[0];
  endfunction

  function automatic logic [1:0] exp_bits(input logic [1:0] f, input int k);
    logic [1:0] r;
    int half, b;
    r = 2'b00;
    half = k / 32;
    case (f)
      2'b10: begin
        b = k % 32;
        if (b < W) r[0] = bit_of(half, b);
      end
      2'b00, 2'b01: begin
        b = (f == 2'b01) ? (k % 32) - 1 : k % 32;
        if (b >= 0 && b < W) begin
          r[0] = bit_of(half, b);
          r[1] = bit_of(half + 2, b);
        end
      end
      default: r = 2'b00;
    endcase
    return r;
  endfunction

  function automatic logic [NC*W-1:0] rand_word();
    return {$urandom, $urandom, $urandom};
  endfunction

  task automatic sclk_cycle(input logic fs_v, input logic do_ld,
                            output logic [1:0] got, output logic [1:0] late);
    @(negedge clk);
    sclk = 1'b0;
    fs   = fs_v;
    if (do_ld) begin
      ld_valid = 1'b1;
      ld_data  = pend_w;
    end
    @(negedge clk);
    ld_valid = 1'b0;
    repeat (6) @(negedge clk);
    got  = sdata;
    sclk = 1'b1;
    repeat (8) @(negedge clk);
    late = sdata;
  endtask

  task automatic idle(input logic lvl, input int n);
    logic [1:0] g, l;
    for (int i = 0; i < n; i++) sclk_cycle(lvl, 1'b0, g, l);
  endtask

  task automatic load(input logic [NC*W-1:0] w);
    chk("R7 ready before load", {1'b0, ld_ready}, 2'b01);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_data  = w;
    @(negedge clk);
    ld_valid = 1'b0;
    pend_w   = w;
    pend_vld = 1'b1;
    chk("R7 ready after load", {1'b0, ld_ready}, 2'b00);
  endtask

  task automatic run_frame(input logic [1:0] f, input logic mid, input string pre);
    int fl;
    logic fs_v, do_ld;
    logic [1:0] got, late;
    string tag;
    fl = (f == 2'b10) ? 128 : 64;
    if (pend_vld) begin
      cur_w    = pend_w;
      pend_vld = 1'b0;
    end
    for (int k = 0; k < fl; k++) begin
      case (f)
        2'b10:   fs_v = (k == 0);
        2'b01:   fs_v = (k >= 32);
        default: fs_v = (k < 32);
      endcase
      do_ld = mid && (k == 10);
      if (do_ld) begin
        pend_w   = rand_word();
        pend_vld = 1'b1;
      end
      sclk_cycle(fs_v, do_ld, got, late);
      case (f)
        2'b11:   tag = "R1";
        2'b10:   tag = ((k % 32) >= W) ? "R4" : "R3";
        2'b01:   tag = "R6";
        default: tag = "R5";
      endcase
      if (mid && k > 10) tag = {tag, " R8 mid-frame load"};
      chk({pre, tag}, got, exp_bits(f, k));
      chk("R2 stable while sclk high", late, got);
      if (k == 5) chk("R7 ready after frame start", {1'b0, ld_ready}, {1'b0, ~pend_vld});
      if (mid && k == 12) chk("R7 ready low while held", {1'b0, ld_ready}, 2'b00);
    end
  endtask

  task automatic do_fmt(input logic [1:0] f, input logic [NC*W-1:0] w);
    fmt = f;
    idle(f == 2'b01, 4);
    load(w);
    run_frame(f, 1'b1, "");
    run_frame(f, 1'b0, "R8 next frame ");
  endtask

  initial begin
    void'($urandom(32'd7321));
    fmt = 2'b00; sclk = 1'b1; fs = 1'b0; ld_valid = 1'b0; ld_data = '0;
    cur_w = '0; pend_w = '0; pend_vld = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 data after reset", sdata, 2'b00);
    chk("R9 ready after reset", {1'b0, ld_ready}, 2'b01);

    idle(1'b0, 4);
    run_frame(2'b00, 1'b0, "R9 zero samples ");

    do_fmt(2'b00, {24'hA5A5A5, 24'h000000, 24'h800001, 24'hFFFFFF});
    do_fmt(2'b01, {24'h000001, 24'hFFFFFE, 24'h5A5A5A, 24'h800000});
    do_fmt(2'b10, {24'hFFFFFF, 24'h123456, 24'h000000, 24'hC00003});

    fmt = 2'b11;
    idle(1'b0, 2);
    load(rand_word());
    run_frame(2'b11, 1'b0, "");

    for (int i = 0; i < 6; i++) do_fmt(2'($urandom % 3), rand_word());

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule